// File: doc/BRIEF.md
# Idle-Mode Power Management Controller

This block is the state machine that moves a processor subsystem between Run and Idle. Any bus master can ask for Idle by writing a sleep code into the control register. The controller then raises an idle request to the CPU and waits for the CPU to acknowledge it. After the acknowledge it gates the CPU clock and the clocks of the local data memory and the local program memory. The gates appear as enable outputs.

While the block is in Idle, traffic on a local memory bus turns that memory's clock back on for as long as the transaction lasts, and the CPU stays asleep. Any of these events brings the subsystem back to Run at once: an enabled interrupt, an NMI pin, the watchdog count passing its midpoint, an external power-on or hardware reset, or a software reset written to the reset-request address. The controller also reports a wake-cause code. The code tells the CPU whether to resume in place, vector to a handler, or begin the reset sequence.

Top module: `idle_power_ctrl`

## Requirements
- R1: A write to the control address (0) with wdata[1:0] = 2'b01 while in Run moves the state to Requesting. The state reads back in ctl_rdata[5:4] as Run = 0, Requesting = 1, Idle = 2. Writes of any other sleep code, and any control write outside Run, are ignored.
- R2: cpu_idle_req is high exactly while the state is Requesting. The state stays Requesting until cpu_idle_ack or a wake event arrives.
- R3: Idle is entered only on the cycle after a sampled cpu_idle_ack during Requesting. In Idle, cpu_clk_en is 0. Outside Idle, cpu_clk_en and every mem_clk_en bit are 1.
- R4: In Idle, mem_clk_en[i] follows mem_busy[i], with bit 0 for the data memory and bit 1 for the program memory. A memory access never wakes the CPU.
- R5: In Idle, each wake event returns the state to Run on the next clock edge. The wake events are irq_req, nmi_pin, hw_reset_evt, a software reset, and a watchdog crossing. On that edge the controller also issues a one-cycle wake_valid with wake_cause.
- R6: A watchdog crossing is a change of wdt_count from 0x7FFF to 0x8000 between two consecutive cycles. Any other change of wdt_count is not a wake event.
- R7: wake_cause uses 2'b00 for resume (watchdog), 2'b01 for interrupt, 2'b10 for NMI and 2'b11 for reset. When events coincide, reset wins over NMI, NMI over watchdog, and watchdog over interrupt.
- R8: A software reset is a write to address 1 with wdata[0] = 1. It counts as a reset-class wake. reset_seq_start pulses together with wake_valid exactly when wake_cause is 2'b11.
- R9: A wake event during Requesting aborts the Idle entry. The state returns to Run without ever gating a clock, and the wake is reported the same way as from Idle.
- R10: The sleep field ctl_rdata[1:0] reads 2'b01 while Requesting or Idle and 2'b00 after any wake or abort. Wake events in Run produce no wake_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe from any bus master |
| bus_addr | input | ADDR_W | Write address (0 control, 1 reset request) |
| bus_wdata | input | DATA_W | Write data |
| ctl_rdata | output | DATA_W | Control register readback: sleep field [1:0], state [5:4] |
| cpu_idle_req | output | 1 | Idle request to the CPU |
| cpu_idle_ack | input | 1 | CPU has finished its current operation |
| irq_req | input | 1 | Interrupt pending from an enabled source |
| nmi_pin | input | 1 | External NMI request |
| hw_reset_evt | input | 1 | Power-on or hardware reset event |
| wdt_count | input | WDT_W | Watchdog counter value |
| mem_busy | input | N_MEM | Local bus transaction active, per memory |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| mem_clk_en | output | N_MEM | Local memory clock gate enables |
| wake_valid | output | 1 | One-cycle wake report |
| wake_cause | output | 2 | Wake cause code, held until the next wake |
| reset_seq_start | output | 1 | One-cycle start of the reset sequence |

## Verification
The assertions assume the following about the inputs:
- cpu_idle_ack is meaningful only while cpu_idle_req is high.
- mem_busy may change at any time.
- wdt_count is an ordinary counter value sampled once per cycle.

The stimulus keeps to these assumptions. It raises the acknowledge only during Requesting, holds each event input for exactly one cycle, and walks the watchdog count through chosen neighbouring values, including near-miss steps such as 0x7FFF to 0x8001.

// File: rtl/idle_pmc_pkg.sv
package idle_pmc_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_REQ  = 2'd1,
    ST_IDLE = 2'd2
  } pm_state_e;

  typedef enum logic [1:0] {
    WK_RESUME = 2'b00,
    WK_IRQ    = 2'b01,
    WK_NMI    = 2'b10,
    WK_RESET  = 2'b11
  } wake_cause_e;

  localparam logic [1:0] SLEEP_CODE_IDLE = 2'b01;
  localparam logic [1:0] SLEEP_CODE_NONE = 2'b00;

  // True when a counter of width w steps from just below its midpoint to the midpoint
  function automatic logic mid_crossing(input logic [31:0] prev_v,
                                        input logic [31:0] cur_v,
                                        input int unsigned w);
    logic [31:0] mid;
    mid = 32'd1 << (w - 1);
    return (prev_v == (mid - 32'd1)) && (cur_v == mid);
  endfunction

  // Fixed-priority cause selection: reset > nmi > watchdog > interrupt
  function automatic wake_cause_e pick_cause(input logic rst_any,
                                             input logic nmi,
                                             input logic wdt,
                                             input logic irq);
    if (rst_any)  return WK_RESET;
    else if (nmi) return WK_NMI;
    else if (wdt) return WK_RESUME;
    else if (irq) return WK_IRQ;
    else          return WK_RESUME;
  endfunction

endpackage

// File: rtl/pmc_wake_arb.sv
module pmc_wake_arb
  import idle_pmc_pkg::*;
#(
  parameter int unsigned WDT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic             nmi_pin,
  input  logic             hw_reset_evt,
  input  logic             sw_reset_evt,
  input  logic [WDT_W-1:0] wdt_count,
  output logic             wake_any,
  output wake_cause_e      wake_code,
  output logic             wdt_hit
);

  logic [WDT_W-1:0] wdt_prev;
  logic             rst_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_prev <= '0;
    else        wdt_prev <= wdt_count;
  end

  always_comb begin
    rst_any   = hw_reset_evt | sw_reset_evt;
    wdt_hit   = mid_crossing(32'(wdt_prev), 32'(wdt_count), WDT_W);
    wake_any  = rst_any | nmi_pin | wdt_hit | irq_req;
    wake_code = pick_cause(rst_any, nmi_pin, wdt_hit, irq_req);
  end

  // R6: a crossing needs the count one cycle earlier to be just below the midpoint
  a_r6_wdt_prev_value: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_hit |-> ($past(wdt_count) == {1'b0, {(WDT_W-1){1'b1}}}));

  // R7: a reset-class event always wins the cause
  a_r7_reset_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_evt || sw_reset_evt) |-> (wake_any && wake_code == WK_RESET));

endmodule

// File: rtl/pmc_mem_gate.sv
module pmc_mem_gate #(
  parameter int unsigned N_MEM = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gated,
  input  logic [N_MEM-1:0] mem_busy,
  output logic [N_MEM-1:0] mem_clk_en
);

  for (genvar g = 0; g < N_MEM; g++) begin : g_mem
    always_comb mem_clk_en[g] = ~gated | mem_busy[g];

    // R3: ungated memories always run
    a_r3_mem_free_running: assert property (@(posedge clk) disable iff (!rst_n)
      !gated |-> mem_clk_en[g]);

    // R4: a pending transaction keeps its own memory clocked during Idle
    a_r4_access_wakes_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (gated && mem_busy[g]) |-> mem_clk_en[g]);
  end

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import idle_pmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTL_ADDR = 0,
  parameter int unsigned RST_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cpu_idle_ack,
  input  logic              wake_any,
  input  wake_cause_e       wake_code,
  output logic              sw_reset_evt,
  output pm_state_e         state,
  output logic [1:0]        sleep_field,
  output logic              cpu_idle_req,
  output logic              gated,
  output logic              wake_valid,
  output wake_cause_e       wake_cause,
  output logic              reset_seq_start
);

  pm_state_e state_nx;
  logic      ctl_wr;
  logic      sleep_wr;
  logic      wake_fire;

  always_comb begin
    ctl_wr       = bus_we && (bus_addr == ADDR_W'(CTL_ADDR));
    sleep_wr     = ctl_wr && (bus_wdata[1:0] == SLEEP_CODE_IDLE);
    sw_reset_evt = bus_we && (bus_addr == ADDR_W'(RST_ADDR)) && bus_wdata[0];
    wake_fire    = (state != ST_RUN) && wake_any;
    state_nx     = state;
    unique case (state)
      ST_RUN:  if (sleep_wr) state_nx = ST_REQ;
      ST_REQ:  if (wake_any) state_nx = ST_RUN;
               else if (cpu_idle_ack) state_nx = ST_IDLE;
      ST_IDLE: if (wake_any) state_nx = ST_RUN;
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= ST_RUN;
      sleep_field     <= SLEEP_CODE_NONE;
      wake_valid      <= 1'b0;
      wake_cause      <= WK_RESUME;
      reset_seq_start <= 1'b0;
    end else begin
      state           <= state_nx;
      wake_valid      <= wake_fire;
      reset_seq_start <= wake_fire && (wake_code == WK_RESET);
      if (wake_fire) wake_cause <= wake_code;
      if (state_nx == ST_RUN)                    sleep_field <= SLEEP_CODE_NONE;
      else if (state == ST_RUN && sleep_wr)      sleep_field <= SLEEP_CODE_IDLE;
    end
  end

  always_comb begin
    cpu_idle_req = (state == ST_REQ);
    gated        = (state == ST_IDLE);
  end

  // R3: Idle is only reached through an acknowledged request
  a_r3_idle_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && state_nx == ST_IDLE) |-> cpu_idle_ack);

  // R2: without ack or wake, the request is held
  a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && !cpu_idle_ack && !wake_any) |=> (state == ST_REQ));

  // R5: any wake leaves Idle on the next edge with a report
  a_r5_wake_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wake_any) |=> (state == ST_RUN && wake_valid));

  // R8: reset sequencing coincides with a reset-class report
  a_r8_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seq_start |-> (wake_valid && wake_cause == WK_RESET));

  // R9: an aborted request never gates a clock
  a_r9_abort_ungated: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && wake_any) |=> !gated);

  // R10: no report while running
  a_r10_quiet_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> !wake_valid);

endmodule

// File: rtl/idle_power_ctrl.sv
module idle_power_ctrl
  import idle_pmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WDT_W    = 16,
  parameter int unsigned N_MEM    = 2,
  parameter int unsigned CTL_ADDR = 0,
  parameter int unsigned RST_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              cpu_idle_req,
  input  logic              cpu_idle_ack,
  input  logic              irq_req,
  input  logic              nmi_pin,
  input  logic              hw_reset_evt,
  input  logic [WDT_W-1:0]  wdt_count,
  input  logic [N_MEM-1:0]  mem_busy,
  output logic              cpu_clk_en,
  output logic [N_MEM-1:0]  mem_clk_en,
  output logic              wake_valid,
  output logic [1:0]        wake_cause,
  output logic              reset_seq_start
);

  localparam int unsigned STATE_LSB = 4;

  logic        sw_reset_evt;
  logic        wake_any;
  logic        wdt_hit;
  logic        gated;
  logic [1:0]  sleep_field;
  wake_cause_e wake_code;
  wake_cause_e wake_cause_q;
  pm_state_e   state;

  pmc_wake_arb #(.WDT_W(WDT_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req      (irq_req),
    .nmi_pin      (nmi_pin),
    .hw_reset_evt (hw_reset_evt),
    .sw_reset_evt (sw_reset_evt),
    .wdt_count    (wdt_count),
    .wake_any     (wake_any),
    .wake_code    (wake_code),
    .wdt_hit      (wdt_hit)
  );

  pmc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR), .RST_ADDR(RST_ADDR)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_we          (bus_we),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .cpu_idle_ack    (cpu_idle_ack),
    .wake_any        (wake_any),
    .wake_code       (wake_code),
    .sw_reset_evt    (sw_reset_evt),
    .state           (state),
    .sleep_field     (sleep_field),
    .cpu_idle_req    (cpu_idle_req),
    .gated           (gated),
    .wake_valid      (wake_valid),
    .wake_cause      (wake_cause_q),
    .reset_seq_start (reset_seq_start)
  );

  pmc_mem_gate #(.N_MEM(N_MEM)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .gated      (gated),
    .mem_busy   (mem_busy),
    .mem_clk_en (mem_clk_en)
  );

  always_comb begin
    cpu_clk_en = ~gated;
    wake_cause = wake_cause_q;
    ctl_rdata  = '0;
    ctl_rdata[1:0] = sleep_field;
    ctl_rdata[STATE_LSB +: 2] = state;
  end

  // R2: the CPU is never asked to idle while its clock is off
  a_r2_req_clock_on: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_idle_req |-> cpu_clk_en);

  // R4: memory traffic alone never wakes the CPU
  a_r4_cpu_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !wake_any) |=> !cpu_clk_en);

  // R6: a watchdog-only wake reports resume
  a_r6_wdt_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && wdt_hit && !nmi_pin && !hw_reset_evt && !sw_reset_evt)
      |=> (wake_valid && wake_cause == 2'b00));

endmodule

// File: tb/test_idle_power_ctrl.sv
module test_idle_power_ctrl;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int WDT_W  = 16;
  localparam int N_MEM  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] ctl_rdata;
  logic              cpu_idle_req;
  logic              cpu_idle_ack = 1'b0;
  logic              irq_req = 1'b0;
  logic              nmi_pin = 1'b0;
  logic              hw_reset_evt = 1'b0;
  logic [WDT_W-1:0]  wdt_count = '0;
  logic [N_MEM-1:0]  mem_busy = '0;
  logic              cpu_clk_en;
  logic [N_MEM-1:0]  mem_clk_en;
  logic              wake_valid;
  logic [1:0]        wake_cause;
  logic              reset_seq_start;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct { logic [1:0] cause; string req; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  idle_power_ctrl i_idle_power_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctl_rdata(ctl_rdata), .cpu_idle_req(cpu_idle_req),
    .cpu_idle_ack(cpu_idle_ack), .irq_req(irq_req), .nmi_pin(nmi_pin),
    .hw_reset_evt(hw_reset_evt), .wdt_count(wdt_count), .mem_busy(mem_busy),
    .cpu_clk_en(cpu_clk_en), .mem_clk_en(mem_clk_en), .wake_valid(wake_valid),
    .wake_cause(wake_cause), .reset_seq_start(reset_seq_start)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected wake report per observed wake_valid
  always @(negedge clk) begin
    if (rst_n && !done && wake_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R10: actual unexpected wake cause %0d expected none", wake_cause);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, {30'd0, wake_cause}, {30'd0, e.cause});
        check("R8", {31'd0, reset_seq_start}, {31'd0, e.cause == 2'b11});
      end
    end
  end

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic state_is(input string req, input logic [1:0] st, input logic [1:0] fld);
    check(req, ctl_rdata[5:4], {30'd0, st});
    check(req, ctl_rdata[1:0], {30'd0, fld});
  endtask

  task automatic go_idle();
    bus_write(4'd0, 32'h1);
    @(negedge clk); cpu_idle_ack = 1'b1;
    @(negedge clk); cpu_idle_ack = 1'b0;
  endtask

  // Apply event inputs for one cycle; push the expected report first
  task automatic pulse_evt(input logic i, input logic n, input logic h,
                           input logic [1:0] exp_c, input string req);
    @(negedge clk);
    exp_q.push_back('{cause: exp_c, req: req});
    irq_req = i; nmi_pin = n; hw_reset_evt = h;
    @(negedge clk);
    irq_req = 1'b0; nmi_pin = 1'b0; hw_reset_evt = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    state_is("R1", 2'd0, 2'b00);
    check("R3", {31'd0, cpu_clk_en}, 32'd1);
    check("R3", {30'd0, mem_clk_en}, 32'd3);
    check("R2", {31'd0, cpu_idle_req}, 32'd0);

    // other sleep codes ignored
    bus_write(4'd0, 32'h2);
    state_is("R1", 2'd0, 2'b00);
    bus_write(4'd0, 32'h3);
    state_is("R1", 2'd0, 2'b00);

    // request and hold without ack
    bus_write(4'd0, 32'h1);
    state_is("R1", 2'd1, 2'b01);
    check("R2", {31'd0, cpu_idle_req}, 32'd1);
    repeat (3) @(negedge clk);
    check("R2", {31'd0, cpu_idle_req}, 32'd1);
    check("R3", {31'd0, cpu_clk_en}, 32'd1);
    @(negedge clk); cpu_idle_ack = 1'b1;
    @(negedge clk); cpu_idle_ack = 1'b0;
    state_is("R3", 2'd2, 2'b01);
    check("R3", {31'd0, cpu_clk_en}, 32'd0);
    check("R3", {30'd0, mem_clk_en}, 32'd0);
    check("R2", {31'd0, cpu_idle_req}, 32'd0);

    // control write during Idle ignored
    bus_write(4'd0, 32'h0);
    state_is("R1", 2'd2, 2'b01);

    // memory accesses
    mem_busy = 2'b01; #1;
    check("R4", {30'd0, mem_clk_en}, 32'd1);
    @(negedge clk); mem_busy = 2'b10; #1;
    check("R4", {30'd0, mem_clk_en}, 32'd2);
    @(negedge clk); mem_busy = 2'b00;
    @(negedge clk);
    check("R4", {30'd0, mem_clk_en}, 32'd0);
    check("R4", {31'd0, cpu_clk_en}, 32'd0);

    // interrupt wake
    pulse_evt(1, 0, 0, 2'b01, "R5");
    state_is("R10", 2'd0, 2'b00);
    check("R5", {31'd0, cpu_clk_en}, 32'd1);

    // NMI wake
    go_idle();
    pulse_evt(0, 1, 0, 2'b10, "R5");
    state_is("R5", 2'd0, 2'b00);

    // hardware reset wake
    go_idle();
    pulse_evt(0, 0, 1, 2'b11, "R8");

    // software reset wake
    go_idle();
    exp_q.push_back('{cause: 2'b11, req: "R8"});
    bus_write(4'd1, 32'h1);
    state_is("R8", 2'd0, 2'b00);

    // watchdog: near misses then the real crossing
    go_idle();
    @(negedge clk); wdt_count = 16'h7FFE;
    @(negedge clk); wdt_count = 16'h7FFF;
    @(negedge clk); wdt_count = 16'h8001;
    @(negedge clk); wdt_count = 16'h8000;
    @(negedge clk);
    state_is("R6", 2'd2, 2'b01);
    wdt_count = 16'h7FFF;
    @(negedge clk);
    exp_q.push_back('{cause: 2'b00, req: "R6"});
    wdt_count = 16'h8000;
    @(negedge clk);
    state_is("R6", 2'd0, 2'b00);

    // crossing in Run does nothing
    wdt_count = 16'h7FFF;
    @(negedge clk); wdt_count = 16'h8000;
    @(negedge clk);
    state_is("R10", 2'd0, 2'b00);

    // priorities
    go_idle();
    pulse_evt(1, 1, 0, 2'b10, "R7");
    go_idle();
    pulse_evt(0, 1, 1, 2'b11, "R7");
    go_idle();
    @(negedge clk); wdt_count = 16'h7FFF;
    @(negedge clk);
    exp_q.push_back('{cause: 2'b00, req: "R7"});
    wdt_count = 16'h8000; irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;

    // abort during request
    bus_write(4'd0, 32'h1);
    state_is("R9", 2'd1, 2'b01);
    pulse_evt(1, 0, 0, 2'b01, "R9");
    state_is("R9", 2'd0, 2'b00);
    check("R9", {31'd0, cpu_clk_en}, 32'd1);
    check("R9", {30'd0, mem_clk_en}, 32'd3);

    // events in Run: no report
    @(negedge clk); irq_req = 1'b1; nmi_pin = 1'b1;
    @(negedge clk); irq_req = 1'b0; nmi_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", {31'd0, wake_valid}, 32'd0);
    check("R10", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule